// File: doc/BRIEF.md
# HDLC Receive Frame Assembler

This block sits behind an HDLC receiver that already handles deframing and CRC. The receiver places incoming bytes in a 32-byte FIFO and signals two events. The first, "pool full", means 32 bytes are waiting. The second, "message end", means the frame has closed and comes with a status byte and a residual byte count. The assembler drains the FIFO into a linear frame buffer and checks the status. It then either streams the completed frame out with its length or throws it away.

After every FIFO burst, and after every frame it rejects, the block raises a one-cycle acknowledge. The acknowledge tells the receiver that it may release that FIFO space. A frame length limit guards the buffer: a burst that would bring the buffer fill up to the limit, or past it, is not read. The collected data is discarded instead.

An extended status mode changes the acceptance rule. In that mode a valid-frame bit is also required, and the last collected byte is a status byte that is stripped from the frame. The assembler acts on events only while `idle` is high. If several events arrive in the same idle cycle, the overflow event wins over message end, and message end wins over pool full.

Top module: `hdlc_rx_assembler`

## Requirements
- R1: A pool-full event reads exactly 32 bytes from the FIFO, one per cycle with `fifo_rd` high, and appends them to the frame buffer.
- R2: On message end, the residual count is `rx_count[4:0]`, and a value of 0 means 32. The upper bits are ignored. The frame is exactly the bytes read since the previous message end.
- R3: In basic mode (`ext_mode`=0), the frame is accepted only when `rx_status & 8'h70 == 8'h20`. Bit 6 is overflow, bit 5 is CRC good and bit 4 is abort. A rejected frame reads nothing from the FIFO.
- R4: In extended mode, the frame is accepted only when `rx_status & 8'hF0 == 8'hA0`, which adds bit 7 as the valid-frame flag.
- R5: If the buffer fill plus the burst size would be MAX_LEN or more, the burst is not read, the buffer fill returns to zero, and the acknowledge is still given.
- R6: `ack` is a single-cycle pulse. It follows every read burst, every overrun drop and every rejected frame, so each event gives exactly one pulse.
- R7: In extended mode the delivered length is the collected count minus one. A frame whose delivered length would be below 1 is not delivered.
- R8: In extended mode, a FIFO overflow event (`fifo_ovf`) gives one acknowledge and no read or output. In basic mode, `fifo_ovf` has no effect.
- R9: The buffer fill returns to zero after every message end, whether the frame was delivered or dropped.
- R10: An accepted frame is sent as `out_len` consecutive cycles with `out_valid` high, bytes in arrival order and `out_last` high only on the final byte. `out_len` holds the delivered length throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects the extended status layout |
| pool_full | input | 1 | Event: 32 bytes waiting in the FIFO |
| msg_end | input | 1 | Event: frame closed; status and count valid |
| fifo_ovf | input | 1 | Event: receive FIFO overflow (extended mode) |
| rx_status | input | 8 | Frame status byte, sampled with msg_end |
| rx_count | input | 8 | Byte count register, sampled with msg_end |
| fifo_rd | output | 1 | Pop one byte from the FIFO |
| fifo_data | input | 8 | FIFO head byte, valid while fifo_rd is high |
| ack | output | 1 | Receive message complete acknowledge |
| idle | output | 1 | Events are accepted in this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| out_len | output | $clog2(MAX_LEN) | Delivered frame length |

## Verification
The main sweep builds frames from zero, one or two pool-full bursts followed by every residual count from 0 to 31, in both modes. This separates the 0-means-32 rule, the strip of one byte in extended mode, the drop of short frames and the overrun boundary at MAX_LEN. A second sweep walks the four upper status bits over all sixteen values in each mode, which tells the two acceptance patterns apart. Separate sequences send an overflow event in each mode, and send a rejected frame carrying a full burst followed by a good frame, to show that stale bytes never leak into the next frame.

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler #(
  parameter int MAX_LEN = 72,
  parameter int POOL    = 32,
  localparam int IW = $clog2(MAX_LEN),
  localparam int RW = $clog2(POOL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          pool_full,
  input  logic          msg_end,
  input  logic          fifo_ovf,
  input  logic [7:0]    rx_status,
  input  logic [7:0]    rx_count,
  output logic          fifo_rd,
  input  logic [7:0]    fifo_data,
  output logic          ack,
  output logic          idle,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic [IW-1:0] out_len
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_ACK, S_EMIT} state_t;

  state_t        state;
  logic [7:0]    mem [MAX_LEN];
  logic [IW-1:0] wr, rd;
  logic [RW-1:0] rem;
  logic          is_end, drop;

  logic [RW-1:0] res_cnt;
  logic [IW:0]   sum_end, sum_pool;
  logic          stat_ok, over_end, over_pool;
  logic [IW-1:0] strip;

  assign res_cnt   = (rx_count[4:0] == 5'd0) ? RW'(POOL) : RW'(rx_count[4:0]);
  assign stat_ok   = ext_mode ? ((rx_status & 8'hF0) == 8'hA0)
                              : ((rx_status & 8'h70) == 8'h20);
  assign sum_end   = {1'b0, wr} + (IW+1)'(res_cnt);
  assign sum_pool  = {1'b0, wr} + (IW+1)'(POOL);
  assign over_end  = sum_end  >= (IW+1)'(MAX_LEN);
  assign over_pool = sum_pool >= (IW+1)'(MAX_LEN);
  assign strip     = IW'(ext_mode);

  assign idle      = state == S_IDLE;
  assign fifo_rd   = state == S_READ;
  assign ack       = state == S_ACK;
  assign out_valid = state == S_EMIT;
  assign out_data  = mem[rd];
  assign out_last  = out_valid && (rd == out_len - IW'(1));

  always_ff @(posedge clk)
    if (state == S_READ) mem[wr] <= fifo_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wr      <= '0;
      rd      <= '0;
      rem     <= '0;
      is_end  <= 1'b0;
      drop    <= 1'b0;
      out_len <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (fifo_ovf && ext_mode) begin
            is_end <= 1'b0;
            state  <= S_ACK;
          end else if (msg_end) begin
            is_end <= 1'b1;
            if (!stat_ok) begin
              drop  <= 1'b1;
              state <= S_ACK;
            end else if (over_end) begin
              drop  <= 1'b1;
              wr    <= '0;
              state <= S_ACK;
            end else begin
              drop  <= 1'b0;
              rem   <= res_cnt;
              state <= S_READ;
            end
          end else if (pool_full) begin
            is_end <= 1'b0;
            if (over_pool) begin
              wr    <= '0;
              state <= S_ACK;
            end else begin
              rem   <= RW'(POOL);
              state <= S_READ;
            end
          end
        end
        S_READ: begin
          wr  <= wr + IW'(1);
          rem <= rem - RW'(1);
          if (rem == RW'(1)) state <= S_ACK;
        end
        S_ACK: begin
          state <= S_IDLE;
          if (is_end) begin
            wr <= '0;
            if (!drop && wr > strip) begin
              out_len <= wr - strip;
              rd      <= '0;
              state   <= S_EMIT;
            end
          end
        end
        S_EMIT: begin
          rd <= rd + IW'(1);
          if (rd == out_len - IW'(1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module hdlc_rx_assembler_chk #(
  parameter int MAX_LEN = 72,
  localparam int IW = $clog2(MAX_LEN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_rd,
  input logic          ack,
  input logic          idle,
  input logic          out_valid,
  input logic          out_last,
  input logic [IW-1:0] out_len
);
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_burst_then_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_rd) |-> ack);
  assert_len_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= IW'(1) && out_len < IW'(MAX_LEN)));
  assert_contiguous_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && $stable(out_len)));
  assert_last_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> idle);
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_rd && (out_valid || ack)));
endmodule

bind hdlc_rx_assembler hdlc_rx_assembler_chk #(.MAX_LEN(MAX_LEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .fifo_rd(fifo_rd), .ack(ack), .idle(idle),
  .out_valid(out_valid), .out_last(out_last), .out_len(out_len)
);

// File: tb/test_hdlc_rx_assembler.sv
module test_hdlc_rx_assembler;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN = 72;
  localparam int IW = $clog2(MAX_LEN);

  logic clk = 0, rst_n = 0;
  logic ext_mode = 0, pool_full = 0, msg_end = 0, fifo_ovf = 0;
  logic [7:0] rx_status = 0, rx_count = 0, fifo_data;
  logic fifo_rd, ack, idle, out_valid, out_last;
  logic [7:0] out_data;
  logic [IW-1:0] out_len;

  int errors = 0, checks = 0;
  int seq = 0, ncap = 0, nack = 0, caplen = 0;
  logic [7:0] cap [256];
  logic lastf [256];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_assembler #(.MAX_LEN(MAX_LEN)) i_hdlc_rx_assembler (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .pool_full(pool_full),
    .msg_end(msg_end), .fifo_ovf(fifo_ovf), .rx_status(rx_status),
    .rx_count(rx_count), .fifo_rd(fifo_rd), .fifo_data(fifo_data), .ack(ack),
    .idle(idle), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_len(out_len));

  function automatic logic [7:0] byte_of(int n);
    return 8'((n * 7 + 3) & 255);
  endfunction

  assign fifo_data = byte_of(seq);
  always @(posedge clk) if (fifo_rd) seq <= seq + 1;

  always @(negedge clk) begin
    if (out_valid && ncap < 256) begin
      cap[ncap] = out_data; lastf[ncap] = out_last; caplen = int'(out_len);
      ncap++;
    end
    if (ack) nack++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!idle) @(negedge clk);
  endtask

  task automatic pulse_pool();
    pool_full = 1; @(negedge clk); pool_full = 0;
    while (!idle) @(negedge clk);
  endtask

  task automatic pulse_end(input logic [7:0] st, input logic [7:0] cnt);
    rx_status = st; rx_count = cnt; msg_end = 1;
    @(negedge clk); msg_end = 0;
    while (!idle) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_frame(input bit ext, input int pools, input int res, input logic [7:0] st);
    int s0, total, reads, n, len, expn;
    bit ok, ovr;
    ext_mode = ext; ncap = 0; nack = 0; s0 = seq;
    total = 0; reads = 0; ovr = 0;
    for (int p = 0; p < pools; p++) begin
      if (total + 32 >= MAX_LEN) begin total = 0; ovr = 1; end
      else begin total += 32; reads += 32; end
      pulse_pool();
    end
    pulse_end(st, {3'b101, 5'(res)});
    ok = ext ? ((st & 8'hF0) == 8'hA0) : ((st & 8'h70) == 8'h20);
    n = (res == 0) ? 32 : res;
    if (ok) begin
      if (total + n >= MAX_LEN) begin total = 0; ovr = 1; end
      else begin total += n; reads += n; end
    end
    len = total - int'(ext);
    expn = (ok && len >= 1) ? len : 0;
    check(nack == pools + 1, "R6 acks", nack, pools + 1);
    check(seq - s0 == reads, ovr ? "R5 reads" : (pools > 0 ? "R1 reads" : "R2 reads"),
          seq - s0, reads);
    check(ncap == expn, !ok ? (ext ? "R4 accept" : "R3 accept") : (ext ? "R7 length" : "R2 length"),
          ncap, expn);
    if (expn > 0 && ncap == expn) begin
      int bad = 0;
      for (int i = 0; i < expn; i++)
        if (cap[i] !== byte_of(s0 + i) || lastf[i] !== (i == expn - 1)) bad++;
      check(bad == 0 && caplen == expn, "R10 stream", bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(idle === 1 && out_valid === 0 && ack === 0 && fifo_rd === 0, "R10 reset", int'(idle), 1);
    rst_n = 1;
    @(negedge clk);
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 3; p++)
        for (int r = 0; r < 32; r++)
          run_frame(e[0], p, r, e[0] ? 8'hA3 : 8'h2C);
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 16; s++)
        run_frame(e[0], 0, 5, {4'(s), 4'h6});
    // R8: overflow event
    for (int e = 0; e < 2; e++) begin
      int s0;
      ext_mode = e[0]; nack = 0; ncap = 0; s0 = seq;
      fifo_ovf = 1; @(negedge clk); fifo_ovf = 0;
      wait_idle(); repeat (2) @(negedge clk);
      check(nack == e && ncap == 0 && seq == s0, "R8 overflow", nack, e);
    end
    // R9: rejected frame holding a full burst, then a fresh frame
    run_frame(1'b0, 1, 3, 8'h60);
    run_frame(1'b0, 0, 4, 8'h20);
    check(ncap == 4, "R9 fresh frame", ncap, 4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule